// File: doc/BRIEF.md
# Vertical-Crosswise 4x4 Unsigned Multiplier

This block multiplies two unsigned 4-bit operands and returns their full 8-bit product with no clock and no storage. Each operand is cut into a high pair of bits and a low pair of bits. Four identical 2x2 sub-multipliers form the four cross products at the same time. Three ripple-carry adders of 4, 6 and 7 bits then merge the cross products into the result.

The two lowest product bits come straight from the low-by-low sub-product and pass through no adder. The first adder sums the two middle cross products. The second adder places the high-by-high product above that sum. The third adder folds in the upper half of the low-by-low sub-product. Adder bits above product bit 7 carry no weight and are discarded.

The block is meant for a datapath that needs a small, shallow multiply with a fixed width. A result is valid once its inputs have settled.

Top module: `vc_mul4`

## Requirements
- R1: For every pair of operands, prod_o equals the unsigned arithmetic product a_i × b_i.
- R2: Bit 0 of prod_o equals a_i[0] AND b_i[0]. Bits [1:0] of prod_o equal the low two bits of a_i[1:0] × b_i[1:0].
- R3: When both operands are below 4, so that only their low halves are nonzero, prod_o[7:4] is zero and prod_o[3:0] equals the product, which is at most 9.
- R4: When either operand is zero, prod_o is zero.
- R5: When one operand is 1, prod_o equals the other operand, zero-extended.
- R6: The largest case, 15 × 15, gives 225 (0xE1). Adder output bits above product bit 7 are always zero and never reach the output.
- R7: When both operands have zero low halves (a_i = 4x, b_i = 4y), prod_o equals 16·x·y and prod_o[3:0] is zero.
- R8: The block is purely combinational. prod_o follows any change of a_i or b_i within the same time step, with no clock or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | Unsigned multiplicand |
| b_i | input | 4 | Unsigned multiplier |
| prod_o | output | 8 | Unsigned product a_i × b_i |

## Verification
Two merges can contribute to the same product bits for one operand pair. The first is the carry out of the middle-product adder. The second is the high-by-high product together with the folded-in upper half of the low-by-low term. Operands with both halves large, such as 15 × 15, 14 × 11 and 13 × 15, drive carries from the middle adder into the bits that the high-by-high term also fills. Every such result is compared with the arithmetic product computed in the bench. The exhaustive sweep over all 256 pairs covers every overlap of the two merges.

// File: rtl/vc_mul4.sv
module vc_mul4 (
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  output logic [7:0] prod_o
);
  localparam int OPW = 4;
  localparam int HW  = OPW / 2;
  localparam int PPW = 2 * HW;
  localparam int NPP = 4;
  localparam int A1W = PPW;
  localparam int A2W = A1W + HW;
  localparam int A3W = A2W + 1;

  // pp[0]=lo*lo, pp[1]=hi(a)*lo(b), pp[2]=lo(a)*hi(b), pp[3]=hi*hi
  logic [NPP-1:0][PPW-1:0] pp;

  for (genvar k = 0; k < NPP; k++) begin : g_sub
    localparam bit AHI = (k % 2) == 1;
    localparam bit BHI = (k / 2) == 1;
    logic [HW-1:0] x, y;
    logic c1;
    assign x = AHI ? a_i[OPW-1:HW] : a_i[HW-1:0];
    assign y = BHI ? b_i[OPW-1:HW] : b_i[HW-1:0];
    assign c1 = (x[1] & y[0]) & (x[0] & y[1]);
    assign pp[k] = {(x[1] & y[1]) & c1,
                    (x[1] & y[1]) ^ c1,
                    (x[1] & y[0]) ^ (x[0] & y[1]),
                    x[0] & y[0]};
  end

  logic [A1W-1:0] s1;
  logic           co1;
  always_comb begin
    logic c;
    c = 1'b0;
    for (int i = 0; i < A1W; i++) begin
      s1[i] = pp[1][i] ^ pp[2][i] ^ c;
      c     = (pp[1][i] & pp[2][i]) | (c & (pp[1][i] ^ pp[2][i]));
    end
    co1 = c;
  end

  logic [A2W-1:0] x2, y2, s2;
  logic           co2;
  assign x2 = {pp[3], {HW{1'b0}}};
  assign y2 = {{(A2W-A1W-1){1'b0}}, co1, s1};
  always_comb begin
    logic c;
    c = 1'b0;
    for (int i = 0; i < A2W; i++) begin
      s2[i] = x2[i] ^ y2[i] ^ c;
      c     = (x2[i] & y2[i]) | (c & (x2[i] ^ y2[i]));
    end
    co2 = c;
  end

  logic [A3W-1:0] x3, y3, s3;
  logic           co3;
  assign x3 = {co2, s2};
  assign y3 = {{(A3W-HW){1'b0}}, pp[0][PPW-1:HW]};
  always_comb begin
    logic c;
    c = 1'b0;
    for (int i = 0; i < A3W; i++) begin
      s3[i] = x3[i] ^ y3[i] ^ c;
      c     = (x3[i] & y3[i]) | (c & (x3[i] ^ y3[i]));
    end
    co3 = c;
  end

  assign prod_o = {s3[A2W-1:0], pp[0][HW-1:0]};

  always_comb begin
    // R2
    low_bit_chk: assert (prod_o[0] == (a_i[0] & b_i[0]));
    // R3
    for (int k = 0; k < NPP; k++) begin
      sub_range_chk: assert (pp[k] <= 4'd9);
    end
    // R4
    if (a_i == '0 || b_i == '0) begin
      zero_operand_chk: assert (prod_o == '0);
    end
    // R5
    if (a_i == 4'd1) begin
      unit_operand_chk: assert (prod_o == {4'd0, b_i});
    end
    // R6
    no_overflow_chk: assert ({co3, s3[A3W-1]} == 2'b00);
  end
endmodule

// File: tb/test_vc_mul4.sv
module test_vc_mul4;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  logic [3:0] a, b;
  logic [7:0] prod;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  vc_mul4 i_vc_mul4 (.a_i(a), .b_i(b), .prod_o(prod));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, act, exp);
    end
  endtask

  task automatic apply(input int x, input int y);
    a = 4'(x);
    b = 4'(y);
    #1;
  endtask

  initial begin
    // R4 and R8: initial state with zero operands
    apply(0, 0);
    check("R4", prod, 8'd0);

    // R1: exhaustive sweep
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++) begin
        apply(x, y);
        check("R1", prod, 8'(x * y));
      end

    // R2: low product bits
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++) begin
        apply(x, y);
        check("R2", {6'd0, prod[1:0]}, 8'(((x % 4) * (y % 4)) % 4));
      end

    // R3: low halves only
    for (int x = 0; x < 4; x++)
      for (int y = 0; y < 4; y++) begin
        apply(x, y);
        check("R3", prod, 8'(x * y));
      end

    // R4: zero operand on either side
    for (int x = 0; x < 16; x++) begin
      apply(x, 0);
      check("R4", prod, 8'd0);
      apply(0, x);
      check("R4", prod, 8'd0);
    end

    // R5: unit operand
    for (int x = 0; x < 16; x++) begin
      apply(1, x);
      check("R5", prod, 8'(x));
      apply(x, 1);
      check("R5", prod, 8'(x));
    end

    // R6: maximum and heavy-carry cases
    apply(15, 15); check("R6", prod, 8'hE1);
    apply(14, 11); check("R6", prod, 8'd154);
    apply(13, 15); check("R6", prod, 8'd195);

    // R7: high halves only
    for (int x = 0; x < 4; x++)
      for (int y = 0; y < 4; y++) begin
        apply(4 * x, 4 * y);
        check("R7", prod, 8'(16 * x * y));
      end

    // R8: output follows an input change in the same time step
    apply(9, 7);
    a = 4'd6;
    #1;
    check("R8", prod, 8'd42);
    b = 4'd3;
    #1;
    check("R8", prod, 8'd18);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule